// File: doc/BRIEF.md
# Bootstrap Instruction Stream Generator

This block sits on the memory bus of an 8-bit CPU from reset onward. While bootstrap mode is active it does not look at the memory address. Instead, every memory read the CPU makes receives the next byte of a fixed, pre-ordered stream. First comes a short preamble. Then a copy loop runs 256 times: each pass is a two-byte block-copy opcode followed by a data read, and each data read receives the next byte of an internal 256-byte boot image. A jump back to address zero follows, and last an I/O write instruction that addresses the exit port. Because the stream is served by position, the same address can return different bytes at different times. CPU writes during the copy go straight to RAM. The block neither sees nor changes them.

Each served read is stretched by a wait request held for a programmable number of clocks. An I/O write to the exit port (F8h by default) leaves bootstrap mode. From then on the block never drives the bus or raises wait again, so RAM answers at full speed.

Top module: `boot_stream_gen`

## Requirements
- R1: After reset, bootstrap mode is active, `boot_rdata_en` is low and `boot_wait` is low until a memory read begins.
- R2: The first six served reads return AFh, D3h, F0h, 11h, 02h, 00h in that order, whatever the state of `cpu_m1`.
- R3: Next follow 256 copy groups. In each group the first two M1 reads return EDh and then A0h. The non-M1 read after them returns image byte k, equal to (37*k + 29) mod 256, for group index k counting from 0.
- R4: After image byte 255 the served reads return C3h, 00h, 00h, then D3h, F8h.
- R5: For every served read, `boot_wait` goes high one clock after the read strobe rises and stays high for exactly WAIT_CYCLES (default 8) clocks.
- R6: While a served read is in progress, `boot_rdata_en` is high and `boot_rdata` is held constant. The enable falls in the same cycle the read strobe falls.
- R7: An I/O write to any port other than the exit port has no effect on the mode or on the stream position.
- R8: An I/O write to the exit port (`cpu_port` = F8h) ends bootstrap mode at any stream position. After it, memory reads are not driven and raise no wait.
- R9: Once the final F8h byte has been served, later memory reads are not driven and raise no wait, even before the exit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_mem_rd | input | 1 | Memory read strobe, active high, held for the whole access |
| cpu_m1 | input | 1 | High when the current read is an opcode fetch |
| cpu_io_wr | input | 1 | I/O write strobe, active high |
| cpu_port | input | 8 | Low address byte (I/O port number) during I/O writes |
| boot_rdata | output | 8 | Byte to place on the CPU data bus |
| boot_rdata_en | output | 1 | High when `boot_rdata` must drive the bus instead of RAM |
| boot_wait | output | 1 | Wait request that stretches a served read |

## Verification
The hardest state to reach is the end of the stream. The last image byte, the switch to the jump bytes and the hold state after the final F8h can only be reached by walking all 256 copy groups, and every read in that walk is held for the full wait window. The bench replays the whole boot sequence as a scripted bus master that waits out each stretch before it drops the strobe. It then probes an extra read in the hold state and checks that a second exit, forced in mid-preamble after a fresh reset, stops service at once.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [2:0] {
    PH_PRE,
    PH_LOOP,
    PH_TAIL,
    PH_EXIT,
    PH_HOLD
  } bsg_phase_e;

  localparam int PRE_LEN  = 6;
  localparam int TAIL_LEN = 3;
  localparam int EXIT_LEN = 2;

  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_COPY   = 8'hA0;

  // preamble: clear accumulator, select bank, load destination pointer
  function automatic logic [7:0] pre_byte(input logic [2:0] i);
    case (i)
      3'd0:    pre_byte = 8'hAF;
      3'd1:    pre_byte = 8'hD3;
      3'd2:    pre_byte = 8'hF0;
      3'd3:    pre_byte = 8'h11;
      3'd4:    pre_byte = 8'h02;
      default: pre_byte = 8'h00;
    endcase
  endfunction

  // jump back to zero
  function automatic logic [7:0] tail_byte(input logic [1:0] i);
    tail_byte = (i == 2'd0) ? 8'hC3 : 8'h00;
  endfunction

  // final I/O write that names the exit port
  function automatic logic [7:0] exit_byte(input logic i);
    exit_byte = i ? 8'hF8 : 8'hD3;
  endfunction

  // computed boot image content
  function automatic logic [7:0] img_byte(input logic [15:0] k);
    logic [15:0] t;
    t = k * 16'd37 + 16'd29;
    img_byte = t[7:0];
  endfunction

endpackage

// File: rtl/bsg_busmon.sv
module bsg_busmon #(
  parameter logic [7:0] EXIT_PORT = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_rd,
  input  logic       io_wr,
  input  logic [7:0] io_port,
  output logic       boot_o,
  output logic       rd_start_o
);

  logic rd_q, rd_d;
  logic io_q, io_d;
  logic boot_q, boot_d;
  logic io_start;

  assign io_start   = io_wr & ~io_q;
  assign rd_start_o = mem_rd & ~rd_q;
  assign boot_o     = boot_q;

  always_comb begin
    rd_d   = mem_rd;
    io_d   = io_wr;
    boot_d = boot_q;
    if (io_start && (io_port == EXIT_PORT)) begin
      boot_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      io_q   <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      rd_q   <= rd_d;
      io_q   <= io_d;
      boot_q <= boot_d;
    end
  end

endmodule

// File: rtl/bsg_seq.sv
module bsg_seq
  import bsg_pkg::*;
#(
  parameter int IMG_LEN = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       step_m1,
  output logic [7:0] byte_o,
  output logic       avail_o
);

  localparam int IDX_W = ($clog2(IMG_LEN) < 3) ? 3 : $clog2(IMG_LEN);
  localparam logic [IDX_W-1:0] IMG_LAST  = IDX_W'(IMG_LEN - 1);
  localparam logic [IDX_W-1:0] PRE_LAST  = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] TAIL_LAST = IDX_W'(TAIL_LEN - 1);
  localparam logic [IDX_W-1:0] EXIT_LAST = IDX_W'(EXIT_LEN - 1);
  localparam logic [IDX_W-1:0] ONE       = IDX_W'(1);

  bsg_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             odd_q, odd_d;

  assign avail_o = (phase_q != PH_HOLD);

  always_comb begin
    case (phase_q)
      PH_PRE:  byte_o = pre_byte(idx_q[2:0]);
      PH_LOOP: byte_o = step_m1 ? (odd_q ? OP_COPY : OP_PREFIX)
                                : img_byte(16'(idx_q));
      PH_TAIL: byte_o = tail_byte(idx_q[1:0]);
      PH_EXIT: byte_o = exit_byte(idx_q[0]);
      default: byte_o = 8'h00;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    odd_d   = odd_q;
    if (step) begin
      case (phase_q)
        PH_PRE: begin
          if (idx_q == PRE_LAST) begin
            phase_d = PH_LOOP;
            idx_d   = '0;
            odd_d   = 1'b0;
          end else begin
            idx_d = idx_q + ONE;
          end
        end
        PH_LOOP: begin
          if (step_m1) begin
            odd_d = ~odd_q;
          end else begin
            odd_d = 1'b0;
            if (idx_q == IMG_LAST) begin
              phase_d = PH_TAIL;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + ONE;
            end
          end
        end
        PH_TAIL: begin
          if (idx_q == TAIL_LAST) begin
            phase_d = PH_EXIT;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + ONE;
          end
        end
        PH_EXIT: begin
          if (idx_q == EXIT_LAST) begin
            phase_d = PH_HOLD;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + ONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRE;
      idx_q   <= '0;
      odd_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      odd_q   <= odd_d;
    end
  end

endmodule

// File: rtl/bsg_stretch.sv
module bsg_stretch #(
  parameter int WAIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy_o
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy_o = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/boot_stream_gen.sv
module boot_stream_gen #(
  parameter int         IMG_LEN     = 256,
  parameter int         WAIT_CYCLES = 8,
  parameter logic [7:0] EXIT_PORT   = 8'hF8,
  parameter int         RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_mem_rd,
  input  logic       cpu_m1,
  input  logic       cpu_io_wr,
  input  logic [7:0] cpu_port,
  output logic [7:0] boot_rdata,
  output logic       boot_rdata_en,
  output logic       boot_wait
);

  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_s = rs_q[RST_STAGES-1];

  logic       boot_act;
  logic       rd_start;
  logic       seq_avail;
  logic [7:0] seq_byte;
  logic       serve_start;

  bsg_busmon #(.EXIT_PORT(EXIT_PORT)) u_busmon (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mem_rd     (cpu_mem_rd),
    .io_wr      (cpu_io_wr),
    .io_port    (cpu_port),
    .boot_o     (boot_act),
    .rd_start_o (rd_start)
  );

  assign serve_start = rd_start & boot_act & seq_avail;

  bsg_seq #(.IMG_LEN(IMG_LEN)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .step    (serve_start),
    .step_m1 (cpu_m1),
    .byte_o  (seq_byte),
    .avail_o (seq_avail)
  );

  bsg_stretch #(.WAIT_CYCLES(WAIT_CYCLES)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load   (serve_start),
    .busy_o (boot_wait)
  );

  logic [7:0] data_q, data_d;
  logic       serve_q, serve_d;

  always_comb begin
    data_d  = data_q;
    serve_d = serve_q & cpu_mem_rd;
    if (serve_start) begin
      data_d  = seq_byte;
      serve_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      data_q  <= 8'h00;
      serve_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      serve_q <= serve_d;
    end
  end

  assign boot_rdata    = data_q;
  assign boot_rdata_en = serve_q & cpu_mem_rd;

endmodule

// File: rtl/bsg_chk.sv
module bsg_chk #(
  parameter int         WAIT_CYCLES = 8,
  parameter logic [7:0] EXIT_PORT   = 8'hF8
) (
  input logic       clk,
  input logic       rst_n_s,
  input logic       io_wr,
  input logic [7:0] port,
  input logic       drv_en,
  input logic [7:0] rdata,
  input logic       wait_req
);

  logic        exited_q;
  logic        en_q;
  logic        first_done_q;
  logic [15:0] wrun_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      exited_q     <= 1'b0;
      en_q         <= 1'b0;
      first_done_q <= 1'b0;
      wrun_q       <= '0;
    end else begin
      if (io_wr && (port == EXIT_PORT)) exited_q <= 1'b1;
      en_q <= drv_en;
      if (drv_en && !en_q) first_done_q <= 1'b1;
      if (wait_req) begin
        if (wrun_q != 16'hFFFF) wrun_q <= wrun_q + 16'd1;
      end else begin
        wrun_q <= '0;
      end
    end
  end

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (drv_en && !en_q && !first_done_q) |-> (rdata == 8'hAF)); // R2

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n_s)
    wait_req |-> (wrun_q < 16'(WAIT_CYCLES))); // R5

  AST_WAIT_WITH_SERVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(wait_req) |-> drv_en); // R5

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (drv_en && en_q) |-> $stable(rdata)); // R6

  AST_SILENT_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n_s)
    exited_q |-> (!drv_en && !wait_req)); // R8

endmodule

bind boot_stream_gen bsg_chk #(
  .WAIT_CYCLES (WAIT_CYCLES),
  .EXIT_PORT   (EXIT_PORT)
) u_chk (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .io_wr    (cpu_io_wr),
  .port     (cpu_port),
  .drv_en   (boot_rdata_en),
  .rdata    (boot_rdata),
  .wait_req (boot_wait)
);

// File: tb/boot_stream_gen_tb.sv
module boot_stream_gen_tb;

  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_mem_rd = 1'b0;
  logic       cpu_m1 = 1'b0;
  logic       cpu_io_wr = 1'b0;
  logic [7:0] cpu_port = 8'h00;
  logic [7:0] boot_rdata;
  logic       boot_rdata_en;
  logic       boot_wait;

  int checks = 0;
  int errors = 0;

  int exp_byte[$];
  bit exp_m1[$];

  boot_stream_gen #(.WAIT_CYCLES(W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_mem_rd    (cpu_mem_rd),
    .cpu_m1        (cpu_m1),
    .cpu_io_wr     (cpu_io_wr),
    .cpu_port      (cpu_port),
    .boot_rdata    (boot_rdata),
    .boot_rdata_en (boot_rdata_en),
    .boot_wait     (boot_wait)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input bit m1, input int b);
    exp_m1.push_back(m1);
    exp_byte.push_back(b);
  endtask

  // served read compared every clock against the reference
  task automatic served_rd(input string req);
    bit m1;
    int b;
    m1 = exp_m1.pop_front();
    b  = exp_byte.pop_front();
    @(negedge clk);
    cpu_mem_rd = 1'b1;
    cpu_m1     = m1;
    for (int j = 1; j <= W + 1; j++) begin
      @(negedge clk);
      chk(boot_rdata_en == 1'b1, "R6 enable", int'(boot_rdata_en), 1);
      chk(boot_rdata == 8'(b), req, int'(boot_rdata), b);
      chk(boot_wait == (j <= W), "R5 wait", int'(boot_wait), int'(j <= W));
    end
    cpu_mem_rd = 1'b0;
    cpu_m1     = 1'b0;
    #1;
    chk(boot_rdata_en == 1'b0, "R6 release", int'(boot_rdata_en), 0);
  endtask

  task automatic quiet_rd(input string req);
    @(negedge clk);
    cpu_mem_rd = 1'b1;
    for (int j = 1; j <= W + 1; j++) begin
      @(negedge clk);
      chk(boot_rdata_en == 1'b0, req, int'(boot_rdata_en), 0);
      chk(boot_wait == 1'b0, req, int'(boot_wait), 0);
    end
    cpu_mem_rd = 1'b0;
  endtask

  task automatic io_write(input logic [7:0] p);
    @(negedge clk);
    cpu_io_wr = 1'b1;
    cpu_port  = p;
    @(negedge clk);
    cpu_io_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(boot_rdata_en == 1'b0, "R1 enable", int'(boot_rdata_en), 0);
    chk(boot_wait == 1'b0, "R1 wait", int'(boot_wait), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();

    // R2 preamble, with an ignored port write after the bank select (R7)
    push(1, 8'hAF); push(1, 8'hD3); push(0, 8'hF0);
    push(1, 8'h11); push(0, 8'h02); push(0, 8'h00);
    for (int k = 0; k < 3; k++) served_rd("R2 preamble");
    io_write(8'hF0);
    for (int k = 0; k < 3; k++) served_rd("R7 stream continues");

    // R3 copy loop
    for (int k = 0; k < 256; k++) begin
      push(1, 8'hED);
      push(1, 8'hA0);
      push(0, (37 * k + 29) % 256);
      served_rd("R3 prefix");
      served_rd("R3 opcode");
      served_rd("R3 image");
    end

    // R4 tail and exit instruction
    push(1, 8'hC3); push(0, 8'h00); push(0, 8'h00);
    push(1, 8'hD3); push(0, 8'hF8);
    for (int k = 0; k < 5; k++) served_rd("R4 tail");

    quiet_rd("R9 hold");
    io_write(8'hF8);
    quiet_rd("R8 after exit");

    // early exit from mid-preamble
    do_reset();
    push(1, 8'hAF); push(1, 8'hD3);
    served_rd("R2 restart");
    served_rd("R2 restart");
    io_write(8'hF8);
    quiet_rd("R8 early exit");
    cpu_m1 = 1'b1;
    quiet_rd("R8 early exit m1");
    cpu_m1 = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule